// File: doc/BRIEF.md
# Read Burst Address Sequencer

This block is the read half of a memory-mapped slave. It takes one read request at a time from an AXI4 read-address channel and works out the address of every beat for fixed, incrementing and wrapping bursts. For each beat it makes one read of a whole aligned bus word on a simple target port. When the target answers, the block returns that word on the AXI4 read-data channel. When the target reports a failure for a beat, only that beat carries zero data and a slave-error response.

The request is fixed when it is accepted. The beat size is clamped to the bus width. Wrap boundaries come from the total burst size. A one-cycle protocol-error flag marks requests that break the burst rules, and the burst is still served. The address channel stays closed until the final beat of the current burst has been handed over.

Top module: `rd_burst_seq`

## Requirements
- R1: A burst returns exactly `ar_len`+1 beats. `r_last` is 1 on the final beat only, and `r_valid` falls after the final handshake.
- R2: Every returned beat carries `r_id` equal to the `ar_id` of the accepted request.
- R3: Burst code 0 (fixed): every beat reads the word that contains the start address, rounded down to the beat size.
- R4: Burst code 1 (incrementing): the beat address starts at the request address rounded down to 2^`ar_size` bytes and grows by 2^`ar_size` per beat. Every target read address is a multiple of the bus width in bytes.
- R5: Burst code 2 (wrapping, 2/4/8/16 beats): the address walks up from the start and returns to the start rounded down to the total burst size when it reaches that base plus the total size.
- R6: For a beat narrower than the bus, `r_data` still carries the full bus word that the target returned for the word-aligned address.
- R7: A beat whose target read reports `tgt_err` returns all-zero data with `r_resp`=2'b10. Every other beat returns the target data with `r_resp`=2'b00.
- R8: `prot_err` is 1 for exactly the cycle after acceptance of an incrementing burst whose span crosses a 4096-byte boundary. The burst is still served in full.
- R9: `prot_err` is also raised for an `ar_size` wider than the bus (the size is clamped to the bus width), for a wrapping burst whose length is not 2, 4, 8 or 16 beats, and for the reserved burst code 3. Both of the last two cases are served as incrementing bursts.
- R10: `ar_ready` is 0 from acceptance until the final R handshake. While `r_valid` is high and `r_ready` is low, the data, response and last flag hold steady and the beat does not advance.
- R11: Synchronous reset aborts any burst. Afterwards `r_valid`, `tgt_req` and `prot_err` are 0 and `ar_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request accepted when high with ar_valid |
| ar_id | input | ID_W | Request tag |
| ar_addr | input | ADDR_W | Start byte address |
| ar_len | input | 8 | Beats minus one |
| ar_size | input | 3 | log2 of bytes per beat |
| ar_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken when high with r_valid |
| r_id | output | ID_W | Tag of the burst |
| r_data | output | DATA_W | Beat data |
| r_resp | output | 2 | 2'b00 okay, 2'b10 slave error |
| r_last | output | 1 | Final beat of burst |
| tgt_req | output | 1 | One-cycle target read strobe |
| tgt_addr | output | ADDR_W | Word-aligned target read address |
| tgt_rsp_valid | input | 1 | Target read answer present |
| tgt_rdata | input | DATA_W | Target read word |
| tgt_err | input | 1 | Target read failed |
| prot_err | output | 1 | One-cycle flag for an illegal request |

## Verification
The bench builds the block with a 16-bit address, a 32-bit data bus (four lanes) and a 4-bit tag. The short address lets the vectors put an incrementing burst across a 4096-byte page. The four lanes make byte and half-word beats sub-word, so partly shared words and the clamp of an 8-byte size request can both be reached. The target model returns a word derived from its own address, so every beat's data shows which word was read. It fails on one chosen word, which lets a fault hit one beat or two adjacent narrow beats.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/rbs_req_decode.sv
// Turns a raw read request into start address, effective size, walking
// mode and wrap mask, and flags rule violations. ADDR_W must be >= 12.
module rbs_req_decode
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic [ADDR_W-1:0] start_addr,
  output logic [2:0]        eff_size,
  output burst_e            mode,
  output logic [ADDR_W-1:0] wrap_mask,
  output logic              perr
);
  localparam int         MAX_SIZE = (LANES > 1) ? $clog2(LANES) : 0;
  localparam logic [2:0] MAX_SZ   = 3'(MAX_SIZE);
  localparam int         TOT_W    = 10 + MAX_SIZE;
  localparam int         PG_W     = TOT_W + 13;

  logic [TOT_W-1:0]  beats_n;
  logic [TOT_W-1:0]  total;
  logic [ADDR_W-1:0] lane_mask;
  logic [PG_W-1:0]   page_end;
  logic              oversize;
  logic              wrap_len_ok;
  logic              crosses;

  always_comb begin
    oversize    = (ar_size > MAX_SZ);
    eff_size    = oversize ? MAX_SZ : ar_size;
    beats_n     = TOT_W'(ar_len) + TOT_W'(1);
    total       = beats_n << eff_size;
    lane_mask   = (ADDR_W'(1) << eff_size) - ADDR_W'(1);
    start_addr  = ar_addr & ~lane_mask;
    wrap_mask   = ADDR_W'(total - TOT_W'(1));
    wrap_len_ok = (ar_len == 8'd1) || (ar_len == 8'd3) ||
                  (ar_len == 8'd7) || (ar_len == 8'd15);

    case (burst_e'(ar_burst))
      BURST_FIXED: mode = BURST_FIXED;
      BURST_WRAP:  mode = wrap_len_ok ? BURST_WRAP : BURST_INCR;
      default:     mode = BURST_INCR;
    endcase

    page_end = PG_W'(start_addr[11:0]) + PG_W'(total);
    crosses  = (mode == BURST_INCR) && (page_end > PG_W'(4096));

    perr = oversize || crosses ||
           (burst_e'(ar_burst) == BURST_RSVD) ||
           ((burst_e'(ar_burst) == BURST_WRAP) && !wrap_len_ok);
  end
endmodule

// File: rtl/rbs_addr_step.sv
// Next beat address from the current one.
module rbs_addr_step
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  burst_e            mode,
  input  logic [ADDR_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] bumped;

  always_comb begin
    bumped = cur_addr + (ADDR_W'(1) << size);
    case (mode)
      BURST_FIXED: next_addr = cur_addr;
      BURST_WRAP:  next_addr = (cur_addr & ~wrap_mask) | (bumped & wrap_mask);
      default:     next_addr = bumped;
    endcase
  end
endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last,
  output logic              tgt_req,
  output logic [ADDR_W-1:0] tgt_addr,
  input  logic              tgt_rsp_valid,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_err,
  output logic              prot_err
);
  localparam int                LANES     = DATA_W / 8;
  localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(LANES - 1);

  seq_state_e        state;
  logic [ID_W-1:0]   id_q;
  logic [7:0]        len_q;
  logic [7:0]        beat_q;
  logic [2:0]        size_q;
  burst_e            mode_q;
  logic [ADDR_W-1:0] wmask_q;
  logic [ADDR_W-1:0] cur_q;

  logic [ADDR_W-1:0] dec_start;
  logic [2:0]        dec_size;
  burst_e            dec_mode;
  logic [ADDR_W-1:0] dec_wmask;
  logic              dec_perr;
  logic [ADDR_W-1:0] nxt_addr;

  rbs_req_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .ar_addr    (ar_addr),
    .ar_len     (ar_len),
    .ar_size    (ar_size),
    .ar_burst   (ar_burst),
    .start_addr (dec_start),
    .eff_size   (dec_size),
    .mode       (dec_mode),
    .wrap_mask  (dec_wmask),
    .perr       (dec_perr)
  );

  rbs_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr  (cur_q),
    .size      (size_q),
    .mode      (mode_q),
    .wrap_mask (wmask_q),
    .next_addr (nxt_addr)
  );

  assign r_id = id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ar_ready <= 1'b1;
      r_valid  <= 1'b0;
      r_data   <= '0;
      r_resp   <= RESP_OKAY;
      r_last   <= 1'b0;
      tgt_req  <= 1'b0;
      tgt_addr <= '0;
      prot_err <= 1'b0;
      id_q     <= '0;
      len_q    <= '0;
      beat_q   <= '0;
      size_q   <= '0;
      mode_q   <= BURST_INCR;
      wmask_q  <= '0;
      cur_q    <= '0;
    end else begin
      tgt_req  <= 1'b0;
      prot_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ar_valid && ar_ready) begin
            ar_ready <= 1'b0;
            id_q     <= ar_id;
            len_q    <= ar_len;
            beat_q   <= '0;
            size_q   <= dec_size;
            mode_q   <= dec_mode;
            wmask_q  <= dec_wmask;
            cur_q    <= dec_start;
            tgt_req  <= 1'b1;
            tgt_addr <= dec_start & ~WORD_MASK;
            prot_err <= dec_perr;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tgt_rsp_valid) begin
            r_valid <= 1'b1;
            r_data  <= tgt_err ? '0 : tgt_rdata;
            r_resp  <= tgt_err ? RESP_SLVERR : RESP_OKAY;
            r_last  <= (beat_q == len_q);
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (r_ready) begin
            r_valid <= 1'b0;
            if (r_last) begin
              ar_ready <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              beat_q   <= beat_q + 8'd1;
              cur_q    <= nxt_addr;
              tgt_req  <= 1'b1;
              tgt_addr <= nxt_addr & ~WORD_MASK;
              state    <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ID_W-1:0]   ar_id,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic [DATA_W-1:0] r_data,
  input logic [1:0]        r_resp,
  input logic              r_last,
  input logic              tgt_req,
  input logic [ADDR_W-1:0] tgt_addr
);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] WMASK = ADDR_W'(LANES - 1);

  logic [ID_W-1:0] seen_id;
  always_ff @(posedge clk) begin
    if (rst) seen_id <= '0;
    else if (ar_valid && ar_ready) seen_id <= ar_id;
  end

  // R2
  a_r2_id_match: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (r_id == seen_id));
  // R4
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (rst)
    tgt_req |-> ((tgt_addr & WMASK) == '0));
  // R7
  a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_resp == 2'b10) |-> (r_data == '0));
  // R10
  a_r10_addr_closed: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> !ar_ready);
  a_r10_beat_hold: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp) && $stable(r_last)));
  // R1
  a_r1_last_ends: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && r_last) |=> !r_valid);
  // R11
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!r_valid && !tgt_req && ar_ready));
endmodule

bind rd_burst_seq rbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/rd_burst_seq_bench.sv
module rd_burst_seq_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 4;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic [3:0]  id;
    logic [15:0] err;
    logic        stall;
    logic        perr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 8'd3, 3'd2, 2'd1, 4'h3, 16'h7FF0, 1'b0, 1'b0},
    '{16'h0206, 8'd2, 3'd1, 2'd0, 4'h5, 16'h7FF0, 1'b1, 1'b0},
    '{16'h0238, 8'd3, 3'd2, 2'd2, 4'h9, 16'h0230, 1'b0, 1'b0},
    '{16'h0301, 8'd4, 3'd0, 2'd1, 4'h1, 16'h7FF0, 1'b1, 1'b0},
    '{16'h0FF8, 8'd3, 3'd2, 2'd1, 4'hA, 16'h7FF0, 1'b0, 1'b1},
    '{16'h0400, 8'd1, 3'd3, 2'd1, 4'h2, 16'h7FF0, 1'b0, 1'b1},
    '{16'h0500, 8'd2, 3'd2, 2'd2, 4'h4, 16'h7FF0, 1'b0, 1'b1},
    '{16'h0600, 8'd1, 3'd2, 2'd3, 4'h6, 16'h0604, 1'b0, 1'b1},
    '{16'h0716, 8'd7, 3'd1, 2'd2, 4'hF, 16'h0718, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ar_valid = 1'b0;
  logic          ar_ready;
  logic [IW-1:0] ar_id = '0;
  logic [AW-1:0] ar_addr = '0;
  logic [7:0]    ar_len = '0;
  logic [2:0]    ar_size = '0;
  logic [1:0]    ar_burst = '0;
  logic          r_valid;
  logic          r_ready = 1'b0;
  logic [IW-1:0] r_id;
  logic [DW-1:0] r_data;
  logic [1:0]    r_resp;
  logic          r_last;
  logic          tgt_req;
  logic [AW-1:0] tgt_addr;
  logic          tgt_rsp_valid;
  logic [DW-1:0] tgt_rdata;
  logic          tgt_err;
  logic          prot_err;
  logic [AW-1:0] err_word = 16'h7FF0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rd_burst_seq #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW)) u_rd_burst_seq (
    .clk(clk), .rst(rst),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last),
    .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_rsp_valid(tgt_rsp_valid),
    .tgt_rdata(tgt_rdata), .tgt_err(tgt_err), .prot_err(prot_err)
  );

  // Target model: answers one cycle after each strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_rsp_valid <= 1'b0;
      tgt_rdata     <= '0;
      tgt_err       <= 1'b0;
    end else begin
      tgt_rsp_valid <= tgt_req;
      tgt_rdata     <= {tgt_addr, ~tgt_addr};
      tgt_err       <= tgt_req && (tgt_addr == err_word);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    err_word = v.err;
    ar_addr  = v.addr;
    ar_len   = v.len;
    ar_size  = v.size;
    ar_burst = v.burst;
    ar_id    = v.id;
    ar_valid = 1'b1;
    #1;
    while (!ar_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    ar_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int          sz;
    int          nb;
    int          beats;
    int          total;
    bit          wrap;
    bit          fixed;
    logic [15:0] cur;
    logic [15:0] lower;
    logic [15:0] word;
    logic [31:0] exp_data;
    bit          exp_e;
    string       tag;
    int          got;
    bit          tog;
    bit          hold_pend;
    logic [31:0] held;
    sz    = (v.size > 3'd2) ? 2 : int'(v.size);
    nb    = 1 << sz;
    beats = int'(v.len) + 1;
    total = nb * beats;
    fixed = (v.burst == 2'd0);
    wrap  = (v.burst == 2'd2) && (v.len == 8'd1 || v.len == 8'd3 || v.len == 8'd7 || v.len == 8'd15);
    cur   = v.addr & ~16'(nb - 1);
    lower = cur & ~16'(total - 1);
    if (fixed) tag = "R3";
    else if (wrap) tag = "R5";
    else if (sz < 2) tag = "R6";
    else tag = "R4";

    issue(v);
    chk(prot_err == v.perr, (v.burst == 2'd1 && v.size <= 3'd2) ? "R8" : "R9",
        "prot_err after accept", 64'(prot_err), 64'(v.perr));

    got = 0; tog = 1'b0; hold_pend = 1'b0; held = '0;
    while (got < beats) begin
      @(negedge clk);
      r_ready = v.stall ? tog : 1'b1;
      tog = ~tog;
      #1;
      if (hold_pend) begin
        chk(r_valid && r_data == held, "R10", "beat held under stall", 64'(r_data), 64'(held));
      end
      hold_pend = r_valid && !r_ready;
      held = r_data;
      if (r_valid) chk(!ar_ready, "R10", "ar_ready during burst", 64'(ar_ready), 64'd0);
      if (r_valid && r_ready) begin
        word     = cur & 16'hFFFC;
        exp_e    = (word == v.err);
        exp_data = exp_e ? 32'd0 : {word, ~word};
        chk(r_data == exp_data, exp_e ? "R7" : tag, "beat data", 64'(r_data), 64'(exp_data));
        chk(r_resp == (exp_e ? 2'b10 : 2'b00), "R7", "beat resp", 64'(r_resp), exp_e ? 64'd2 : 64'd0);
        chk(r_last == (got == beats - 1), "R1", "last flag", 64'(r_last), 64'(got == beats - 1));
        chk(r_id == v.id, "R2", "beat id", 64'(r_id), 64'(v.id));
        got++;
        if (!fixed) begin
          cur = cur + 16'(nb);
          if (wrap && cur == lower + 16'(total)) cur = lower;
        end
      end
    end
    @(negedge clk);
    r_ready = 1'b0;
    #1;
    chk(!r_valid, "R1", "no beat after last", 64'(r_valid), 64'd0);
    chk(ar_ready, "R10", "ar_ready reopened", 64'(ar_ready), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ar_ready && !r_valid && !tgt_req && !prot_err, "R11", "reset state",
        {60'd0, ar_ready, r_valid, tgt_req, prot_err}, 64'h8);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R11: abort a long burst after its first beat
    issue('{16'h0800, 8'd7, 3'd2, 2'd1, 4'h7, 16'h7FF0, 1'b0, 1'b0});
    while (!r_valid) @(negedge clk);
    r_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    r_ready = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!r_valid && !tgt_req && ar_ready, "R11", "mid-burst reset",
        {61'd0, r_valid, tgt_req, ar_ready}, 64'h1);
    repeat (3) @(negedge clk);
    #1;
    chk(!r_valid, "R11", "no beats while in reset", 64'(r_valid), 64'd0);
    rst = 1'b0;

    run_vec('{16'h0900, 8'd1, 3'd2, 2'd1, 4'hC, 16'h0904, 1'b0, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule